// File: doc/BRIEF.md
# Configuration Sync Word Padder

This block closes out the loading of a device configuration image. Once the image payload has been pushed into the configuration data path, the device may still need extra clocks before it reaches early user mode. On a start pulse the block takes over the data path. Before each filler word it checks the early-user-mode status bit. If that bit is low, it offers one all-ones word and then waits a fixed number of ticks before the next check. It stops when the status bit is seen high, or when a tick budget runs out.

While it pads, the block overrides the clock-to-data ratio field of the configuration engine. At start it takes a copy of the current field value and writes the 1:1 code. On either exit it writes the copied value back. It reports how many filler words were accepted. Both time limits are measured in pulses of a free-running tick input, so one design works with any tick rate. The defaults are a one-tick gap and a 1000-tick budget.

The data output is a valid/ready stream. A word moves only on a cycle where valid and ready are both high. Once valid is raised it stays high, with the same data, until ready is seen. The one exception is a budget expiry: valid is then withdrawn and that word does not count. The sink may hold ready low for any length of time. That time still uses up the budget.

Top module: `cfg_sync_padder`

## Requirements
- R1: After reset, valid, done, timeout and the ratio write strobe are low, the word count is 0 and the ratio output is 0.
- R2: The ratio field is 2 bits: code 0 = 1:1, 1 = 1:2, 2 = 1:4, 3 = 1:8. In the cycle after an idle start pulse, ratio_o is 0 with ratio_we_o high, and the value on ratio_cur_i at the start edge is kept. Later changes of ratio_cur_i have no effect.
- R3: Early user mode is sampled in a check step before every filler word. If it is high, no word is offered and the run ends with done.
- R4: Every offered word is 32'hFFFFFFFF. Valid stays high until ready is seen, unless the run ends by timeout.
- R5: After each accepted word, the block waits INTERVAL_TICKS ticks before the next check. With the tick high on every cycle, accepted words are INTERVAL_TICKS+3 cycles apart.
- R6: word_cnt_o counts only completed handshakes. It is cleared at start and then holds its value after the run ends, until the next start.
- R7: The budget is TIMEOUT_TICKS ticks counted from start, and it advances only on tick cycles. When it expires the run ends with timeout. A handshake that completes in the expiry cycle is still counted.
- R8: In the same cycle as done or timeout, ratio_we_o is high and ratio_o carries the kept value.
- R9: Done and timeout are one-cycle pulses and never occur together. If early user mode is high at a check in the same cycle the budget expires, done wins.
- R10: A start pulse that arrives while a run is active is ignored. The kept ratio value and the run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| early_user_i | input | 1 | Early-user-mode status from the device |
| tick_i | input | 1 | Free-running time-base tick |
| ratio_cur_i | input | RATIO_W | Current clock-to-data ratio field |
| ratio_o | output | RATIO_W | Ratio value to write to the field |
| ratio_we_o | output | 1 | One-cycle write strobe for ratio_o |
| wd_valid_o | output | 1 | Filler word valid |
| wd_ready_i | input | 1 | Sink ready |
| wd_data_o | output | DATA_W | Filler word |
| done_o | output | 1 | Pulse: early user mode reached |
| timeout_o | output | 1 | Pulse: budget expired |
| word_cnt_o | output | CNT_W | Accepted filler words |

## Verification
Two pairs of events can land on the same edge. In the first, the check that sees early user mode can fall on the same edge where the budget expires. In the second, a handshake can complete on the edge where the budget expires. The bench picks a budget of 18 ticks and a gap of 3 ticks. With these values, the check after the third word falls exactly on the expiry edge. A run that raises the status after three words must end in done with a count of 3. A run that waits for a fourth word must end in timeout with a count of 3. The same sweep, plus a run where the sink never accepts a word, confirms that any word accepted before expiry counts and no word is lost.

// File: rtl/cfgpad_pkg.sv
package cfgpad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } pad_state_e;

  localparam int unsigned RATIO_FIELD_W = 2;
  localparam logic [RATIO_FIELD_W-1:0] RATIO_ONE_TO_ONE = '0;
endpackage

// File: rtl/cfgpad_tick_timer.sv
module cfgpad_tick_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear_i)
      cnt_q <= '0;
    else if (tick_i && !expired_o)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfgpad_ratio_keeper.sv
module cfgpad_ratio_keeper #(
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               save_i,
  input  logic               restore_i,
  input  logic [RATIO_W-1:0] cur_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               we_o
);
  logic [RATIO_W-1:0] kept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_q  <= '0;
      ratio_o <= '0;
      we_o    <= 1'b0;
    end else begin
      we_o <= save_i | restore_i;
      if (save_i) begin
        kept_q  <= cur_i;
        ratio_o <= RATIO_W'(cfgpad_pkg::RATIO_ONE_TO_ONE);
      end else if (restore_i) begin
        ratio_o <= kept_q;
      end
    end
  end
endmodule

// File: rtl/cfg_sync_padder.sv
module cfg_sync_padder #(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned RATIO_W        = 2,
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned INTERVAL_TICKS = 1,
  parameter int unsigned TIMEOUT_TICKS  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               early_user_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_cur_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_we_o,
  output logic               wd_valid_o,
  input  logic               wd_ready_i,
  output logic [DATA_W-1:0]  wd_data_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [CNT_W-1:0]   word_cnt_o
);
  import cfgpad_pkg::*;

  localparam logic [DATA_W-1:0] FILL_WORD = {DATA_W{1'b1}};

  pad_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic done_q, to_q;
  logic gap_exp, budget_exp;
  logic hs, start_ok, end_ok, end_to, finish;

  always_comb begin
    hs       = (state_q == ST_SEND) && wd_ready_i;
    start_ok = (state_q == ST_IDLE) && start_i;
    end_ok   = (state_q == ST_CHECK) && early_user_i;
    end_to   = !end_ok && budget_exp &&
               ((state_q == ST_CHECK) ||
                (state_q == ST_SEND && !wd_ready_i) ||
                (state_q == ST_WAIT));
    finish   = end_ok || end_to;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CHECK;
      ST_CHECK: if (finish) state_d = ST_IDLE;
                else state_d = ST_SEND;
      ST_SEND:  if (hs) state_d = ST_WAIT;
                else if (end_to) state_d = ST_IDLE;
      ST_WAIT:  if (end_to) state_d = ST_IDLE;
                else if (gap_exp) state_d = ST_CHECK;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= end_ok;
      to_q    <= end_to;
      if (start_ok)
        cnt_q <= '0;
      else if (hs)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  cfgpad_tick_timer #(.LIMIT(INTERVAL_TICKS)) gap_tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (hs),
    .tick_i    (tick_i),
    .expired_o (gap_exp)
  );

  cfgpad_tick_timer #(.LIMIT(TIMEOUT_TICKS)) budget_tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_ok),
    .tick_i    (tick_i),
    .expired_o (budget_exp)
  );

  cfgpad_ratio_keeper #(.RATIO_W(RATIO_W)) ratio_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .save_i    (start_ok),
    .restore_i (finish),
    .cur_i     (ratio_cur_i),
    .ratio_o   (ratio_o),
    .we_o      (ratio_we_o)
  );

  assign wd_valid_o = (state_q == ST_SEND);
  assign wd_data_o  = FILL_WORD;
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign word_cnt_o = cnt_q;
endmodule

// File: rtl/cfg_sync_padder_checker.sv
module cfg_sync_padder_checker #(
  parameter int unsigned RATIO_W = 2,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               early_user_i,
  input logic               wd_valid_o,
  input logic               wd_ready_i,
  input logic               done_o,
  input logic               timeout_o,
  input logic               ratio_we_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic [CNT_W-1:0]   word_cnt_o
);
  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid_o && !wd_ready_i) |=> (wd_valid_o || timeout_o));

  assert_no_word_after_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_valid_o) |-> !$past(early_user_i));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid_o && wd_ready_i) |=> (word_cnt_o == $past(word_cnt_o) + CNT_W'(1)));

  assert_forced_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid_o |-> (ratio_o == '0));

  assert_restore_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> ratio_we_o);

  assert_exclusive_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

bind cfg_sync_padder cfg_sync_padder_checker #(
  .RATIO_W (RATIO_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .early_user_i (early_user_i),
  .wd_valid_o   (wd_valid_o),
  .wd_ready_i   (wd_ready_i),
  .done_o       (done_o),
  .timeout_o    (timeout_o),
  .ratio_we_o   (ratio_we_o),
  .ratio_o      (ratio_o),
  .word_cnt_o   (word_cnt_o)
);

// File: tb/cfg_sync_padder_tb_top.sv
module cfg_sync_padder_tb_top;
  localparam int T_TICKS = 18;
  localparam int I_TICKS = 3;
  localparam int PERIOD  = I_TICKS + 3;
  localparam int MAXW    = (T_TICKS - 1) / PERIOD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, early_user_i = 1'b0, tick_i = 1'b0, wd_ready_i = 1'b0;
  logic [1:0] ratio_cur_i = 2'd0;
  logic [1:0] ratio_o;
  logic ratio_we_o, wd_valid_o, done_o, timeout_o;
  logic [31:0] wd_data_o;
  logic [15:0] word_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cfg_sync_padder #(
    .DATA_W(32), .RATIO_W(2), .CNT_W(16),
    .INTERVAL_TICKS(I_TICKS), .TIMEOUT_TICKS(T_TICKS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .early_user_i(early_user_i),
    .tick_i(tick_i), .ratio_cur_i(ratio_cur_i), .ratio_o(ratio_o),
    .ratio_we_o(ratio_we_o), .wd_valid_o(wd_valid_o), .wd_ready_i(wd_ready_i),
    .wd_data_o(wd_data_o), .done_o(done_o), .timeout_o(timeout_o),
    .word_cnt_o(word_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // mode 0: sink always ready; 1: sink delays; 2: sink never ready
  task automatic run(input int k, input int v, input int mode, input int tick_hold);
    int hs = 0, vcnt = 0, cyc = 0, last_hs = -1;
    bit fin = 0, got_done = 0, got_to = 0, prev_stall = 0;
    int exp_cnt;
    bit exp_done;
    @(negedge clk);
    ratio_cur_i  = 2'(v);
    early_user_i = (k == 0);
    start_i      = 1'b1;
    tick_i       = (tick_hold == 0);
    wd_ready_i   = (mode == 0);
    @(negedge clk);
    start_i = 1'b0;
    chk(ratio_we_o == 1'b1 && ratio_o == 2'd0, "R2 force 1:1", ratio_o, 0);
    ratio_cur_i = 2'(3 - v);
    while (!fin && cyc < 400) begin
      if (done_o || timeout_o) begin
        fin = 1;
        got_done = done_o;
        got_to = timeout_o;
      end else begin
        if (mode == 1 && prev_stall)
          chk(wd_valid_o == 1'b1, "R4 valid hold", wd_valid_o, 1);
        if (wd_valid_o)
          chk(wd_data_o == 32'hFFFF_FFFF, "R4 fill word", wd_data_o, 32'hFFFF_FFFF);
        if (mode == 1) begin
          if (wd_valid_o) vcnt++;
          wd_ready_i = wd_valid_o && (vcnt >= 3);
        end
        prev_stall = wd_valid_o && !wd_ready_i;
        if (wd_valid_o && wd_ready_i) begin
          hs++;
          vcnt = 0;
          if (mode == 0 && last_hs >= 0)
            chk(cyc - last_hs == PERIOD, "R5 word spacing", cyc - last_hs, PERIOD);
          last_hs = cyc;
          if (hs == k) early_user_i = 1'b1;
        end
        if (tick_hold > 0) begin
          if (cyc == tick_hold - 1)
            chk(!timeout_o && wd_valid_o, "R7 budget frozen without tick", timeout_o, 0);
          tick_i = (cyc >= tick_hold);
        end
        start_i = (cyc == 2);  // R10: pulse while active
        cyc++;
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    if (mode == 0) begin
      exp_done = (k <= MAXW);
      exp_cnt  = (k <= MAXW) ? k : MAXW;
    end else if (mode == 1) begin
      exp_done = 1;
      exp_cnt  = 1;
    end else begin
      exp_done = 0;
      exp_cnt  = 0;
    end
    chk(fin, "R9 run ended", fin, 1);
    chk(got_done == exp_done && got_to == !exp_done, "R3/R7/R9 end kind", got_done, exp_done);
    chk(word_cnt_o == 16'(hs), "R6 count equals handshakes", word_cnt_o, hs);
    chk(word_cnt_o == 16'(exp_cnt), "R6 count expected", word_cnt_o, exp_cnt);
    chk(ratio_we_o && ratio_o == 2'(v), "R8 R10 ratio restored", ratio_o, v);
    @(negedge clk);
    chk(!done_o && !timeout_o, "R9 single-cycle pulse", done_o | timeout_o, 0);
    chk(word_cnt_o == 16'(exp_cnt), "R6 count held", word_cnt_o, exp_cnt);
    chk(!ratio_we_o && ratio_o == 2'(v), "R8 strobe single", ratio_we_o, 0);
    early_user_i = 1'b0;
    wd_ready_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wd_valid_o && !done_o && !timeout_o && !ratio_we_o, "R1 reset outputs", wd_valid_o, 0);
    chk(word_cnt_o == 16'd0 && ratio_o == 2'd0, "R1 reset count/ratio", word_cnt_o, 0);
    for (int k = 0; k <= MAXW + 1; k++)
      run(k, k % 4, 0, 0);   // k == MAXW is the done/expiry collision
    run(1, 2, 1, 0);
    run(99, 3, 2, 0);
    run(99, 1, 2, 40);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule